// File: doc/BRIEF.md
# Sync-latched control register bank

This block is the register file that sits behind a byte-oriented serial bus slave. The slave presents one subaddress and one data byte per transfer, plus a flag that says whether the byte is the upper or the lower half of a 16-bit word. Each register has a fixed implemented width, 16 bits at most, and its own access mode. The modes are:

- write-only
- write/read
- read-only status, which is fed from core inputs
- two shadowed modes, whose written value only reaches the hardware on a rising edge of the frame sync or the line sync

Wide values are assembled from two bytes, upper byte first. The register changes as a whole when the lower byte arrives. Bits above a register's width are dropped on write and return zero on read. The active control words go to the core on a packed output bus. Read data is combinational on the current subaddress and byte flag.

Top module: `ctl_regbank`

## Requirements
- R1: After the asynchronous active-low reset, every control output word is 0 and every write/read or shadow register reads back 0.
- R2: A write with `hi_i`=1 only stages the byte and changes no output. A write with `hi_i`=0 to subaddress N loads `{staged byte, wdata_i}` into register N, and the change shows on the edge that samples it.
- R3: A register of 8 implemented bits or fewer is loaded by a single byte with `hi_i`=0. Writes with `hi_i`=1 leave it unchanged, and its upper read byte is 0.
- R4: Bits at or above a register's width are dropped on write and read back as 0. The default widths are 16, 12, 10, 16, 9 and 8 for subaddresses 0 to 5.
- R5: Write-only register (mode code 0, subaddress 0): its control output follows writes and every read returns 0.
- R6: Write/read register (mode code 1, subaddresses 1 and 5): a read returns the stored value. Bits 15:8 come with `hi_i`=1 and bits 7:0 with `hi_i`=0.
- R7: Read-only status register (mode code 2, subaddress 2): a read returns the masked status input in the same cycle. Writes have no effect, and its control output word stays 0.
- R8: Frame-shadowed register (mode code 3, subaddress 3): writes only reach the shadow. The control output takes the shadow on the third rising clock edge after `vsync_i` rises. Line sync edges do not change it.
- R9: Line-shadowed register (mode code 4, subaddress 4): the same as R8, but with `hsync_i` in place of `vsync_i`. Frame sync edges do not change it.
- R10: A lower-byte write to a shadowed register that lands on the commit edge updates the shadow only. The output keeps the previous shadow value until the next sync edge.
- R11: Reading a shadowed register returns the shadow value, not the active output.
- R12: A subaddress at or beyond the register count reads 0, and writing it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register subaddress |
| hi_i | input | 1 | 1 selects the upper byte, 0 the lower byte |
| wr_en_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for addr_i / hi_i |
| vsync_i | input | 1 | Frame sync, asynchronous |
| hsync_i | input | 1 | Line sync, asynchronous |
| stat_i | input | NREG*16 | Status words from the core, one per register |
| ctrl_o | output | NREG*16 | Active control words, one per register |

## Verification
Read data has no register in its path, so it is due in the same cycle as `addr_i`, `hi_i` or `stat_i` change. A lower-byte write shows on `ctrl_o` one edge later. A sync rise shows three edges later: two synchronizer flops, then the commit itself.

The bench drives inputs on the falling edge and compares shortly after it. At that point every registered result from the preceding rising edge has settled, and so have the combinational reads. A behavioural model steps on the same rising edges and is compared with every output word each cycle. Directed checks for shadowed registers sample at the first, second and third falling edge after the sync rise, so an early or late commit is caught.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [2:0] {
    MODE_W  = 3'd0,
    MODE_WR = 3'd1,
    MODE_RO = 3'd2,
    MODE_VS = 3'd3,
    MODE_HS = 3'd4
  } reg_mode_e;

  function automatic logic [DATA_W-1:0] width_mask(input int unsigned w);
    return DATA_W'((33'd1 << w) - 33'd1);
  endfunction
endpackage

// File: rtl/regbank_sync_rise.sv
module regbank_sync_rise #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // commit strobe is a single-cycle pulse
  assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/regbank_slot.sv
module regbank_slot
  import regbank_pkg::*;
#(
  parameter reg_mode_e   MODE  = MODE_WR,
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              vrise_i,
  input  logic              hrise_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] MASK = width_mask(WIDTH);

  if (MODE == MODE_RO) begin : g_ro
    logic unused_ro;
    assign unused_ro = ^{clk_i, rst_ni, wr_i, wdata_i, vrise_i, hrise_i};
    assign ctrl_o  = '0;
    assign rdata_o = stat_i & MASK;
  end else if (MODE == MODE_VS || MODE == MODE_HS) begin : g_shadow
    logic              commit;
    logic [DATA_W-1:0] shadow_q, act_q;
    logic              unused_sh;
    assign unused_sh = ^stat_i;
    assign commit = (MODE == MODE_VS) ? vrise_i : hrise_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        act_q    <= '0;
      end else begin
        if (wr_i)   shadow_q <= wdata_i & MASK;
        if (commit) act_q    <= shadow_q;   // old shadow: same-edge write waits
      end
    end

    assign ctrl_o  = act_q;
    assign rdata_o = shadow_q;

    assert_commit_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |=> ctrl_o == $past(rdata_o));
    assert_commit_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit |=> $stable(ctrl_o));
    assert_shadow_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> rdata_o == ($past(wdata_i) & MASK));
  end else begin : g_plain
    logic [DATA_W-1:0] val_q;
    logic              unused_pl;
    assign unused_pl = ^{vrise_i, hrise_i, stat_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   val_q <= '0;
      else if (wr_i) val_q <= wdata_i & MASK;
    end

    assign ctrl_o  = val_q;
    assign rdata_o = (MODE == MODE_WR) ? val_q : '0;

    assert_wr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ctrl_o == ($past(wdata_i) & MASK));
    assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(ctrl_o));
    assert_no_upper_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_o & ~MASK) == '0);
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned                NREG      = 6,
  parameter int unsigned                ADDR_W    = 8,
  parameter int unsigned                SYNC_FF   = 2,
  parameter logic [NREG-1:0][2:0]       REG_MODE  = {3'd1, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [NREG-1:0][4:0]       REG_WIDTH = {5'd8, 5'd9, 5'd16, 5'd10, 5'd12, 5'd16}
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         hi_i,
  input  logic                         wr_en_i,
  input  logic [7:0]                   wdata_i,
  output logic [7:0]                   rdata_o,
  input  logic                         vsync_i,
  input  logic                         hsync_i,
  input  logic [NREG-1:0][DATA_W-1:0]  stat_i,
  output logic [NREG-1:0][DATA_W-1:0]  ctrl_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);

  logic                        vrise, hrise;
  logic [7:0]                  stage_q;
  logic [DATA_W-1:0]           wword;
  logic [NREG-1:0][DATA_W-1:0] rd_w;
  logic [DATA_W-1:0]           rd_sel;

  regbank_sync_rise #(.STAGES(SYNC_FF)) i_vsync (
    .clk_i, .rst_ni, .async_i(vsync_i), .rise_o(vrise));
  regbank_sync_rise #(.STAGES(SYNC_FF)) i_hsync (
    .clk_i, .rst_ni, .async_i(hsync_i), .rise_o(hrise));

  // upper byte waits here until the lower byte completes the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stage_q <= '0;
    else if (wr_en_i && hi_i)   stage_q <= wdata_i;
  end

  assign wword = {stage_q, wdata_i};

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic wr;
    assign wr = wr_en_i && !hi_i && (addr_i == ADDR_W'(i));

    regbank_slot #(
      .MODE (reg_mode_e'(REG_MODE[i])),
      .WIDTH(int'(REG_WIDTH[i]))
    ) i_slot (
      .clk_i,
      .rst_ni,
      .wr_i    (wr),
      .wdata_i (wword),
      .vrise_i (vrise),
      .hrise_i (hrise),
      .stat_i  (stat_i[i]),
      .ctrl_o  (ctrl_o[i]),
      .rdata_o (rd_w[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == ADDR_W'(i)) rd_sel = rd_w[i];
    end
  end

  assign rdata_o = hi_i ? rd_sel[15:8] : rd_sel[7:0];

  assert_hi_staged_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hi_i && !vrise && !hrise) |=> $stable(ctrl_o));
  assert_unmapped_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > LAST_ADDR) |-> rdata_o == 8'h00);
  assert_unmapped_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > LAST_ADDR && !vrise && !hrise) |=> $stable(ctrl_o));
endmodule

// File: tb/test_ctl_regbank.sv
`timescale 1ns/1ps
module test_ctl_regbank;
  localparam int NR = 6;
  localparam int MODES [NR]  = '{0, 1, 2, 3, 4, 1};
  localparam int WIDTHS [NR] = '{16, 12, 10, 16, 9, 8};

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic hi = 0, wr_en = 0, vsync = 0, hsync = 0;
  logic [7:0] rdata;
  logic [NR-1:0][15:0] stat = '0, ctrl;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ctl_regbank i_ctl_regbank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .hi_i(hi), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .vsync_i(vsync), .hsync_i(hsync),
    .stat_i(stat), .ctrl_o(ctrl));

  // behavioural reference
  int m_val [NR], m_sh [NR], m_act [NR];
  int m_stage;
  bit v1, v2, v3, h1, h2, h3;

  function automatic int mk(int w);
    return (1 << w) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin m_val[i] = 0; m_sh[i] = 0; m_act[i] = 0; end
      m_stage = 0; v1 = 0; v2 = 0; v3 = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit vr, hr;
      vr = v2 && !v3; hr = h2 && !h3;
      v3 = v2; v2 = v1; v1 = vsync;
      h3 = h2; h2 = h1; h1 = hsync;
      for (int i = 0; i < NR; i++)
        if ((MODES[i] == 3 && vr) || (MODES[i] == 4 && hr)) m_act[i] = m_sh[i];
      if (wr_en) begin
        if (hi) m_stage = wdata;
        else if (addr < NR) begin
          int v;
          v = ((m_stage << 8) | wdata) & mk(WIDTHS[addr]);
          if (MODES[addr] <= 1) m_val[addr] = v;
          else if (MODES[addr] >= 3) m_sh[addr] = v;
        end
      end
    end
  end

  function automatic int exp_ctrl(int i);
    case (MODES[i])
      0, 1: return m_val[i];
      2: return 0;
      default: return m_act[i];
    endcase
  endfunction

  function automatic int exp_rd();
    int w;
    if (addr >= NR) return 0;
    case (MODES[addr])
      0: w = 0;
      1: w = m_val[addr];
      2: w = stat[addr] & mk(WIDTHS[addr]);
      default: w = m_sh[addr];
    endcase
    return hi ? (w >> 8) & 255 : w & 255;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      for (int i = 0; i < NR; i++) chk(cur_req, int'(ctrl[i]), exp_ctrl(i));
      chk(cur_req, int'(rdata), exp_rd());
    end
  end

  task automatic idle();
    @(negedge clk); wr_en = 0;
  endtask
  task automatic wbyte(int a, bit h, int d);
    @(negedge clk); addr = 8'(a); hi = h; wdata = 8'(d); wr_en = 1;
  endtask
  task automatic wr16(int a, int v);
    wbyte(a, 1, v >> 8); wbyte(a, 0, v & 255);
  endtask
  task automatic rdchk(int a, bit h, int exp, string req);
    @(negedge clk); wr_en = 0; addr = 8'(a); hi = h; #1.5;
    chk(req, int'(rdata), exp);
  endtask
  task automatic ctlchk(int i, int exp, string req);
    @(negedge clk); wr_en = 0; #1.5;
    chk(req, int'(ctrl[i]), exp);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    cur_req = "R1";
    for (int i = 0; i < NR; i++) ctlchk(i, 0, "R1");
    rdchk(1, 0, 0, "R1");
    rdchk(3, 1, 0, "R1");

    // R2, R4, R6: 12-bit write/read register
    cur_req = "R2";
    wbyte(1, 1, 8'hAB);
    ctlchk(1, 0, "R2");
    wbyte(1, 0, 8'hCD);
    ctlchk(1, 16'h0BCD, "R2");
    cur_req = "R6";
    rdchk(1, 1, 8'h0B, "R4");
    rdchk(1, 0, 8'hCD, "R6");

    // R5
    cur_req = "R5";
    wr16(0, 16'hBEEF);
    ctlchk(0, 16'hBEEF, "R5");
    rdchk(0, 0, 0, "R5");
    rdchk(0, 1, 0, "R5");

    // R7
    cur_req = "R7";
    stat[2] = 16'hFFFF;
    rdchk(2, 1, 8'h03, "R7");
    rdchk(2, 0, 8'hFF, "R7");
    wr16(2, 16'h5A5A);
    ctlchk(2, 0, "R7");
    stat[2] = 16'h1234;
    rdchk(2, 1, 8'h02, "R7");
    rdchk(2, 0, 8'h34, "R7");

    // R3: 8-bit register
    cur_req = "R3";
    wbyte(5, 0, 8'h77);
    ctlchk(5, 8'h77, "R3");
    wbyte(5, 1, 8'h99);
    ctlchk(5, 8'h77, "R3");
    rdchk(5, 1, 0, "R3");
    rdchk(5, 0, 8'h77, "R3");

    // R8, R11: frame shadow
    cur_req = "R8";
    wr16(3, 16'hCAFE);
    ctlchk(3, 0, "R8");
    rdchk(3, 1, 8'hCA, "R11");
    @(negedge clk); hsync = 1;
    repeat (4) ctlchk(3, 0, "R8");
    hsync = 0;
    @(negedge clk); vsync = 1;
    ctlchk(3, 0, "R8");
    ctlchk(3, 0, "R8");
    ctlchk(3, 16'hCAFE, "R8");
    vsync = 0;

    // R9: line shadow, 9 bits
    cur_req = "R9";
    wr16(4, 16'hFFFF);
    rdchk(4, 1, 8'h01, "R11");
    @(negedge clk); vsync = 1;
    repeat (4) ctlchk(4, 0, "R9");
    vsync = 0;
    @(negedge clk); hsync = 1;
    ctlchk(4, 0, "R9");
    ctlchk(4, 0, "R9");
    ctlchk(4, 16'h01FF, "R9");
    hsync = 0;
    repeat (3) idle();

    // R10: lower byte lands on the commit edge
    cur_req = "R10";
    wbyte(3, 1, 8'h12);
    @(negedge clk); wr_en = 0; vsync = 1;
    idle();
    wbyte(3, 0, 8'h34);
    ctlchk(3, 16'hCAFE, "R10");
    rdchk(3, 1, 8'h12, "R10");
    rdchk(3, 0, 8'h34, "R10");
    vsync = 0;
    repeat (2) idle();
    @(negedge clk); vsync = 1;
    ctlchk(3, 16'hCAFE, "R10");
    ctlchk(3, 16'hCAFE, "R10");
    ctlchk(3, 16'h1234, "R10");
    vsync = 0;

    // R12
    cur_req = "R12";
    rdchk(9, 0, 0, "R12");
    wr16(9, 16'h5555);
    rdchk(9, 1, 0, "R12");
    ctlchk(0, 16'hBEEF, "R12");
    ctlchk(1, 16'h0BCD, "R12");
    repeat (3) idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule